// File: doc/BRIEF.md
# Prioritized Window Overlay with Drop Shadows

This block decides, pixel by pixel, whether one of four rectangular overlay windows covers the current screen position and which 3-bit RGB color is shown there. Windows are placed on a character grid of 15 rows by 30 columns. Each character cell is 12 dots wide and 18 lines tall. The pixel is given as a cell row and column plus a dot and line offset inside that cell. Each window may also have a drop shadow. The shadow size is counted in dots and lines, not in cells.

The geometry, colors and shadow size codes come in on input buses. The per-window enable and shadow-enable bits are kept inside the block. They are written one window at a time through a small write port, and a single clear command turns off every window. The position is registered on entry, and the hit flag and color follow from the registered position and the current settings. Glyph rendering is done elsewhere; this block only produces the window layer.

Top module: `osd_window_overlay`

## Requirements
- R1: After reset every window enable and shadow enable is 0, and the block reports no hit and color 000.
- R2: An enabled window covers a pixel when its cell row lies between the window's first and last row inclusive, and its cell column lies between the first and last column inclusive. The cell grid is 12 dots by 18 lines.
- R3: Where windows overlap, the lowest-numbered window (index 0) is shown and index 3 is the lowest priority.
- R4: A covered pixel outputs its window's 3-bit color code unchanged. The code is red in bit 2, green in bit 1 and blue in bit 0: 000 black, 001 blue, 010 green, 011 cyan, 100 red, 101 magenta, 110 yellow, 111 white.
- R5: The shadow is the window rectangle shifted right by (width code × 2 + 2) dots and down by (height code × 2 + 2) lines, minus the rectangle itself. This gives an L-shaped band to the right and below.
- R6: Inside one window, the body takes precedence over its own shadow. The shadow of a higher-priority window covers the body of a lower-priority window.
- R7: A shadow pixel outputs that window's own shadow color. A shadow appears only when both the window's enable bit and its shadow-enable bit are 1.
- R8: A write stores the enable and shadow-enable bits for the window selected by a 2-bit index. A clear command sets all four enables to 0 at the next edge, and it wins over a write in the same cycle.
- R9: The position inputs are registered. The output for a position appears after the next rising edge and does not change before it.
- R10: When no window body or shadow covers the pixel, the hit flag is 0 and the color is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_row | input | 4 | Character row of the current pixel |
| cell_col | input | 5 | Character column of the current pixel |
| cell_dot | input | 4 | Dot offset inside the cell (0 to 11) |
| cell_line | input | 5 | Line offset inside the cell (0 to 17) |
| win_row_first | input | 16 | First row of each window, 4 bits per window, window 0 in the low bits |
| win_row_last | input | 16 | Last row of each window |
| win_col_first | input | 20 | First column of each window, 5 bits per window |
| win_col_last | input | 20 | Last column of each window |
| win_rgb | input | 12 | Body color of each window, 3 bits per window |
| shd_rgb | input | 12 | Shadow color of each window |
| shd_wcode | input | 8 | Shadow width code of each window, 2 bits per window |
| shd_hcode | input | 8 | Shadow height code of each window |
| sel_we | input | 1 | Write strobe for the enable bits of one window |
| sel_idx | input | 2 | Window selected by the write |
| sel_win_en | input | 1 | Window enable value to store |
| sel_shd_en | input | 1 | Shadow enable value to store |
| clear_win | input | 1 | Clear all four window enables |
| ovl_hit | output | 1 | A window body or shadow covers the pixel |
| ovl_rgb | output | 3 | Color of the covering window layer |

## Verification
The bound checker checks on every cycle that:
- a clear blanks the output at the next edge;
- with no window enabled there is never a hit;
- a miss always shows black;
- wherever window 0's body or shadow lies, window 0's body color or shadow color appears.

The finer points can only be shown by the bench's scenarios, which compare every cycle against a behavioural pixel model:
- the exact inclusive cell edges;
- the L-shaped shadow band at each size code;
- priority among the lower windows and a higher shadow over a lower body;
- clear winning over a simultaneous write;
- the output holding still until the edge after a position change.

// File: rtl/osd_win_pkg.sv
`timescale 1ns/1ps
package osd_win_pkg;
    localparam int WIN_COUNT   = 4;
    localparam int ROW_BITS    = 4;
    localparam int COL_BITS    = 5;
    localparam int DOT_BITS    = 4;
    localparam int LINE_BITS   = 5;
    localparam int CELL_DOTS   = 12;
    localparam int CELL_LINES  = 18;
    localparam int CODE_BITS   = 2;
    localparam int COLOR_BITS  = 3;
    localparam int PIXEL_BITS  = 10;

    // shadow extent in dots or lines for a size code
    function automatic int unsigned shadow_span(input int unsigned code);
        return code * 2 + 2;
    endfunction
endpackage

// File: rtl/osd_win_ctl.sv
`timescale 1ns/1ps
module osd_win_ctl #(
    parameter int N_WIN = osd_win_pkg::WIN_COUNT,
    localparam int SEL_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] idx,
    input  logic             win_d,
    input  logic             shd_d,
    input  logic             clr,
    output logic [N_WIN-1:0] win_q,
    output logic [N_WIN-1:0] shd_q
);
    // enables: clear has precedence over a write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (clr) begin
            win_q <= '0;
        end else if (we) begin
            win_q[idx] <= win_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '0;
        end else if (we) begin
            shd_q[idx] <= shd_d;
        end
    end
endmodule

// File: rtl/osd_win_cover.sv
`timescale 1ns/1ps
module osd_win_cover #(
    parameter int ROW_W  = osd_win_pkg::ROW_BITS,
    parameter int COL_W  = osd_win_pkg::COL_BITS,
    parameter int CODE_W = osd_win_pkg::CODE_BITS,
    parameter int CELL_W = osd_win_pkg::CELL_DOTS,
    parameter int CELL_H = osd_win_pkg::CELL_LINES,
    parameter int PIX_W  = osd_win_pkg::PIXEL_BITS
) (
    input  logic [PIX_W-1:0]  px,
    input  logic [PIX_W-1:0]  py,
    input  logic [ROW_W-1:0]  row_first,
    input  logic [ROW_W-1:0]  row_last,
    input  logic [COL_W-1:0]  col_first,
    input  logic [COL_W-1:0]  col_last,
    input  logic [CODE_W-1:0] wcode,
    input  logic [CODE_W-1:0] hcode,
    input  logic              win_on,
    input  logic              shd_on,
    output logic              body,
    output logic              shade
);
    logic [PIX_W-1:0] x_lo, x_hi, y_lo, y_hi, sw, sh;
    logic             in_body, in_shift;

    always_comb begin
        x_lo = PIX_W'(col_first) * PIX_W'(CELL_W);
        x_hi = (PIX_W'(col_last) + PIX_W'(1)) * PIX_W'(CELL_W);
        y_lo = PIX_W'(row_first) * PIX_W'(CELL_H);
        y_hi = (PIX_W'(row_last) + PIX_W'(1)) * PIX_W'(CELL_H);
        sw   = PIX_W'(osd_win_pkg::shadow_span(32'(wcode)));
        sh   = PIX_W'(osd_win_pkg::shadow_span(32'(hcode)));
        in_body  = (px >= x_lo) && (px < x_hi) && (py >= y_lo) && (py < y_hi);
        in_shift = (px >= x_lo + sw) && (px < x_hi + sw) &&
                   (py >= y_lo + sh) && (py < y_hi + sh);
        body  = win_on && in_body;
        shade = win_on && shd_on && in_shift && !in_body;
    end
endmodule

// File: rtl/osd_win_prio.sv
`timescale 1ns/1ps
module osd_win_prio #(
    parameter int N_WIN = osd_win_pkg::WIN_COUNT,
    parameter int RGB_W = osd_win_pkg::COLOR_BITS
) (
    input  logic [N_WIN-1:0]       body,
    input  logic [N_WIN-1:0]       shade,
    input  logic [N_WIN*RGB_W-1:0] body_rgb,
    input  logic [N_WIN*RGB_W-1:0] shade_rgb,
    output logic                   hit,
    output logic [RGB_W-1:0]       rgb
);
    // walk from lowest to highest priority so index 0 is applied last
    always_comb begin
        hit = 1'b0;
        rgb = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (body[i]) begin
                hit = 1'b1;
                rgb = body_rgb[i*RGB_W +: RGB_W];
            end else if (shade[i]) begin
                hit = 1'b1;
                rgb = shade_rgb[i*RGB_W +: RGB_W];
            end
        end
    end
endmodule

// File: rtl/osd_window_overlay.sv
`timescale 1ns/1ps
module osd_window_overlay #(
    parameter int N_WIN  = osd_win_pkg::WIN_COUNT,
    parameter int ROW_W  = osd_win_pkg::ROW_BITS,
    parameter int COL_W  = osd_win_pkg::COL_BITS,
    parameter int DOT_W  = osd_win_pkg::DOT_BITS,
    parameter int LINE_W = osd_win_pkg::LINE_BITS,
    parameter int CELL_W = osd_win_pkg::CELL_DOTS,
    parameter int CELL_H = osd_win_pkg::CELL_LINES,
    parameter int CODE_W = osd_win_pkg::CODE_BITS,
    parameter int RGB_W  = osd_win_pkg::COLOR_BITS,
    parameter int PIX_W  = osd_win_pkg::PIXEL_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ROW_W-1:0]        cell_row,
    input  logic [COL_W-1:0]        cell_col,
    input  logic [DOT_W-1:0]        cell_dot,
    input  logic [LINE_W-1:0]       cell_line,
    input  logic [N_WIN*ROW_W-1:0]  win_row_first,
    input  logic [N_WIN*ROW_W-1:0]  win_row_last,
    input  logic [N_WIN*COL_W-1:0]  win_col_first,
    input  logic [N_WIN*COL_W-1:0]  win_col_last,
    input  logic [N_WIN*RGB_W-1:0]  win_rgb,
    input  logic [N_WIN*RGB_W-1:0]  shd_rgb,
    input  logic [N_WIN*CODE_W-1:0] shd_wcode,
    input  logic [N_WIN*CODE_W-1:0] shd_hcode,
    input  logic                    sel_we,
    input  logic [$clog2(N_WIN)-1:0] sel_idx,
    input  logic                    sel_win_en,
    input  logic                    sel_shd_en,
    input  logic                    clear_win,
    output logic                    ovl_hit,
    output logic [RGB_W-1:0]        ovl_rgb
);
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DOT_W-1:0]  dot_q;
    logic [LINE_W-1:0] line_q;
    logic [PIX_W-1:0]  px, py;
    logic [N_WIN-1:0]  win_en_q, shd_en_q, body_v, shade_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            dot_q  <= '0;
            line_q <= '0;
        end else begin
            row_q  <= cell_row;
            col_q  <= cell_col;
            dot_q  <= cell_dot;
            line_q <= cell_line;
        end
    end

    assign px = PIX_W'(col_q) * PIX_W'(CELL_W) + PIX_W'(dot_q);
    assign py = PIX_W'(row_q) * PIX_W'(CELL_H) + PIX_W'(line_q);

    osd_win_ctl #(.N_WIN(N_WIN)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sel_we),
        .idx   (sel_idx),
        .win_d (sel_win_en),
        .shd_d (sel_shd_en),
        .clr   (clear_win),
        .win_q (win_en_q),
        .shd_q (shd_en_q)
    );

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        osd_win_cover #(
            .ROW_W(ROW_W), .COL_W(COL_W), .CODE_W(CODE_W),
            .CELL_W(CELL_W), .CELL_H(CELL_H), .PIX_W(PIX_W)
        ) u_cover (
            .px        (px),
            .py        (py),
            .row_first (win_row_first[g*ROW_W +: ROW_W]),
            .row_last  (win_row_last[g*ROW_W +: ROW_W]),
            .col_first (win_col_first[g*COL_W +: COL_W]),
            .col_last  (win_col_last[g*COL_W +: COL_W]),
            .wcode     (shd_wcode[g*CODE_W +: CODE_W]),
            .hcode     (shd_hcode[g*CODE_W +: CODE_W]),
            .win_on    (win_en_q[g]),
            .shd_on    (shd_en_q[g]),
            .body      (body_v[g]),
            .shade     (shade_v[g])
        );
    end

    osd_win_prio #(.N_WIN(N_WIN), .RGB_W(RGB_W)) u_prio (
        .body      (body_v),
        .shade     (shade_v),
        .body_rgb  (win_rgb),
        .shade_rgb (shd_rgb),
        .hit       (ovl_hit),
        .rgb       (ovl_rgb)
    );
endmodule

// File: rtl/osd_window_overlay_chk.sv
`timescale 1ns/1ps
module osd_window_overlay_chk #(
    parameter int N_WIN = 4,
    parameter int RGB_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clear_win,
    input logic                   ovl_hit,
    input logic [RGB_W-1:0]       ovl_rgb,
    input logic [N_WIN*RGB_W-1:0] win_rgb,
    input logic [N_WIN*RGB_W-1:0] shd_rgb,
    input logic [N_WIN-1:0]       win_en_q,
    input logic [N_WIN-1:0]       body_v,
    input logic [N_WIN-1:0]       shade_v
);
    p_clear_blanks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_win |=> !ovl_hit);

    p_idle_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en_q == '0) |-> !ovl_hit);

    p_miss_black_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_hit |-> (ovl_rgb == '0));

    p_top_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
        body_v[0] |-> (ovl_hit && ovl_rgb == win_rgb[RGB_W-1:0]));

    p_top_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shade_v[0] |-> (ovl_hit && ovl_rgb == shd_rgb[RGB_W-1:0]));
endmodule

bind osd_window_overlay osd_window_overlay_chk #(.N_WIN(N_WIN), .RGB_W(RGB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_win (clear_win),
    .ovl_hit   (ovl_hit),
    .ovl_rgb   (ovl_rgb),
    .win_rgb   (win_rgb),
    .shd_rgb   (shd_rgb),
    .win_en_q  (win_en_q),
    .body_v    (body_v),
    .shade_v   (shade_v)
);

// File: tb/osd_window_overlay_test.sv
`timescale 1ns/1ps
module osd_window_overlay_test;
    localparam int NW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic [3:0]  cell_row;
    logic [4:0]  cell_col;
    logic [3:0]  cell_dot;
    logic [4:0]  cell_line;
    logic [15:0] win_row_first, win_row_last;
    logic [19:0] win_col_first, win_col_last;
    logic [11:0] win_rgb, shd_rgb;
    logic [7:0]  shd_wcode, shd_hcode;
    logic        sel_we, sel_win_en, sel_shd_en, clear_win;
    logic [1:0]  sel_idx;
    logic        ovl_hit;
    logic [2:0]  ovl_rgb;

    logic [3:0] c_rf [NW];
    logic [3:0] c_rl [NW];
    logic [4:0] c_cf [NW];
    logic [4:0] c_cl [NW];
    logic [2:0] c_wc [NW];
    logic [2:0] c_sc [NW];
    logic [1:0] c_ww [NW];
    logic [1:0] c_hh [NW];

    for (genvar g = 0; g < NW; g++) begin : g_pack
        assign win_row_first[g*4 +: 4] = c_rf[g];
        assign win_row_last[g*4 +: 4]  = c_rl[g];
        assign win_col_first[g*5 +: 5] = c_cf[g];
        assign win_col_last[g*5 +: 5]  = c_cl[g];
        assign win_rgb[g*3 +: 3]       = c_wc[g];
        assign shd_rgb[g*3 +: 3]       = c_sc[g];
        assign shd_wcode[g*2 +: 2]     = c_ww[g];
        assign shd_hcode[g*2 +: 2]     = c_hh[g];
    end

    osd_window_overlay uut (.*);

    bit          m_en [NW];
    bit          m_sh [NW];
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;
    bit          lat_probe = 0;
    bit          d_we = 0, d_en = 0, d_shd = 0, d_clr = 0;
    int          d_sel = 0;
    bit          pe_h = 0;
    logic [2:0]  pe_c = 3'b000;
    int unsigned seed = 32'h1234_5678;

    task automatic check(input string req, input bit h, input logic [2:0] c,
                         input bit eh, input logic [2:0] ec);
        n_chk++;
        if (h !== eh || c !== ec) begin
            n_fail++;
            $display("FAIL %s: hit=%0b rgb=%03b expected hit=%0b rgb=%03b",
                     req, h, c, eh, ec);
        end
    endtask

    // behavioural pixel model
    task automatic ref_out(input int r, input int c, input int d, input int l,
                           output bit h, output logic [2:0] col);
        int x, y;
        x = c * 12 + d;
        y = r * 18 + l;
        h = 0;
        col = 3'b000;
        for (int i = 0; i < NW; i++) begin
            int xs, xe, ys, ye, sw, sh;
            bit in_b, in_s;
            if (!m_en[i] || h) continue;
            xs = int'(c_cf[i]) * 12;
            xe = (int'(c_cl[i]) + 1) * 12;
            ys = int'(c_rf[i]) * 18;
            ye = (int'(c_rl[i]) + 1) * 18;
            sw = int'(c_ww[i]) * 2 + 2;
            sh = int'(c_hh[i]) * 2 + 2;
            in_b = x >= xs && x < xe && y >= ys && y < ye;
            in_s = m_sh[i] && x >= xs + sw && x < xe + sw && y >= ys + sh && y < ye + sh;
            if (in_b) begin
                h = 1; col = c_wc[i];
            end else if (in_s) begin
                h = 1; col = c_sc[i];
            end
        end
    endtask

    // one cycle: drive at a falling edge, check at the next falling edge
    task automatic cyc(input int r, input int c, input int d, input int l, input string req);
        bit eh;
        logic [2:0] ec;
        cell_row   = 4'(r);
        cell_col   = 5'(c);
        cell_dot   = 4'(d);
        cell_line  = 5'(l);
        sel_we     = d_we;
        sel_idx    = 2'(d_sel);
        sel_win_en = d_en;
        sel_shd_en = d_shd;
        clear_win  = d_clr;
        if (d_clr) begin
            for (int i = 0; i < NW; i++) m_en[i] = 0;
        end else if (d_we) begin
            m_en[d_sel] = d_en;
        end
        if (d_we) m_sh[d_sel] = d_shd;
        d_we = 0; d_clr = 0;
        ref_out(r, c, d, l, eh, ec);
        if (lat_probe) begin
            #1;
            check("R9 (before edge)", ovl_hit, ovl_rgb, pe_h, pe_c);
        end
        @(negedge clk);
        check(req, ovl_hit, ovl_rgb, eh, ec);
        pe_h = eh;
        pe_c = ec;
    endtask

    task automatic scan(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            cyc(int'((seed >> 4) % 15), int'((seed >> 9) % 30),
                int'((seed >> 15) % 12), int'((seed >> 20) % 18), req);
        end
    endtask

    task automatic wr(input int w, input bit en, input bit shd);
        d_we = 1; d_sel = w; d_en = en; d_shd = shd;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            c_rf[i] = '0; c_rl[i] = '0; c_cf[i] = '0; c_cl[i] = '0;
            c_wc[i] = '0; c_sc[i] = '0; c_ww[i] = '0; c_hh[i] = '0;
        end
        rst_n = 0;
        cell_row = '0; cell_col = '0; cell_dot = '0; cell_line = '0;
        sel_we = 0; sel_idx = '0; sel_win_en = 0; sel_shd_en = 0; clear_win = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset", ovl_hit, ovl_rgb, 1'b0, 3'b000);

        // geometry: all windows configured, none enabled
        c_rf[0] = 2;  c_rl[0] = 4;  c_cf[0] = 3;  c_cl[0] = 8;  c_wc[0] = 3'b100; c_sc[0] = 3'b001; c_ww[0] = 1; c_hh[0] = 0;
        c_rf[1] = 3;  c_rl[1] = 6;  c_cf[1] = 6;  c_cl[1] = 12; c_wc[1] = 3'b010; c_sc[1] = 3'b110; c_ww[1] = 2; c_hh[1] = 1;
        c_rf[2] = 0;  c_rl[2] = 7;  c_cf[2] = 0;  c_cl[2] = 14; c_wc[2] = 3'b101; c_sc[2] = 3'b011; c_ww[2] = 0; c_hh[2] = 2;
        c_rf[3] = 9;  c_rl[3] = 12; c_cf[3] = 18; c_cl[3] = 25; c_wc[3] = 3'b111; c_sc[3] = 3'b000; c_ww[3] = 3; c_hh[3] = 3;
        scan(30, "R1 idle");
        scan(20, "R10 miss");

        // window 0 body only
        wr(0, 1, 0);
        cyc(2, 3, 0, 0, "R2 top-left corner");
        cyc(4, 8, 11, 17, "R2 bottom-right corner");
        cyc(2, 2, 11, 0, "R2 left of edge");
        cyc(5, 3, 0, 0, "R2 below edge");
        cyc(1, 5, 5, 17, "R2 above edge");
        scan(200, "R2");
        scan(100, "R4");

        // window 0 with shadow: 4 dots wide, 2 lines tall
        wr(0, 1, 1);
        cyc(2, 9, 0, 0, "R5 right band above shift");
        cyc(2, 9, 3, 2, "R5 right band first line");
        cyc(2, 9, 4, 2, "R5 beyond right band");
        cyc(5, 3, 4, 1, "R5 bottom band");
        cyc(5, 3, 3, 1, "R5 left of bottom band");
        cyc(5, 3, 4, 2, "R5 below bottom band");
        cyc(4, 8, 11, 17, "R6 body over own shadow");
        scan(200, "R5");
        scan(100, "R7");

        // window 1 overlapping, with shadow
        wr(1, 1, 1);
        cyc(3, 7, 0, 0, "R3 overlap 0 over 1");
        cyc(5, 6, 4, 0, "R6 shadow of 0 over body of 1");
        scan(200, "R3");
        scan(100, "R6");

        // windows 2 and 3
        wr(2, 1, 1);
        cyc(0, 0, 0, 0, "R4 window 2 color");
        wr(3, 1, 1);
        cyc(13, 26, 7, 5, "R7 window 3 shadow");
        scan(200, "R4");
        scan(100, "R7 all");

        // latency: output must not move before the edge
        cyc(3, 4, 0, 0, "R9 setup");
        lat_probe = 1;
        scan(100, "R9");
        lat_probe = 0;

        // clear beats simultaneous write
        wr(3, 1, 1);
        d_clr = 1;
        cyc(10, 20, 0, 0, "R8 clear with write");
        cyc(3, 4, 0, 0, "R8 after clear");
        scan(60, "R8");
        scan(40, "R10");
        wr(1, 1, 0);
        cyc(4, 10, 0, 0, "R8 re-enable");
        scan(60, "R8 single");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule